// File: doc/BRIEF.md
# Split Program Memory Fetch Unit

This unit supplies 16-bit program words to a small DSP core. Each request is decided by one unsigned comparison of its word address against a fixed boundary. Addresses below the boundary read a 1024-word internal instruction RAM, which answers in one cycle. Addresses at or above the boundary go out on an external 16-bit read port, and the byte address on that port is twice the word address. That port is a request/acknowledge pair with variable latency.

The unit owns the program counter. An opcode fetch or an immediate fetch reads at the PC and then advances the PC by one, so an instruction that carries an immediate moves the PC forward by two. A data read gives its own address and leaves the PC alone; this serves indirect operands held in program memory. A branch or call can load the PC at any time.

Requests enter on a valid/ready stream. Words leave on a second valid/ready stream. A response stays on the output until the consumer takes it. While a response is held, or while an external read is pending, the request side deasserts ready and no new request is accepted. The RAM load port is a plain write strobe that fills the instruction RAM.

Top module: `pmf_fetch_unit`

## Requirements
- R1: Out of reset, `pc` is 0, `rsp_valid` and `ext_req` are 0, and `req_ready` is 1.
- R2: An accepted request whose word address is below 1024 returns the internal RAM word at that address, with `rsp_valid` high in the cycle right after acceptance. A word written through the load port (`iram_we`) is returned by later reads of its address.
- R3: An accepted request whose word address is 1024 or more (unsigned) raises `ext_req` in the next cycle, with `ext_addr` equal to twice the word address, 17 bits wide.
- R4: In the cycle where `ext_req` and `ext_ack` are both high, `ext_data` is captured. In the next cycle `ext_req` is low and `rsp_valid` is high, carrying that word.
- R5: A fetch (`req_fetch`=1) reads at the current `pc`, and `pc` becomes `pc`+1 modulo 2^16, so 0xFFFF wraps to 0.
- R6: A data read (`req_fetch`=0) reads at `req_addr` and leaves `pc` unchanged.
- R7: When `pc_load` is high, `pc` takes `pc_load_val` in the next cycle and the increment is dropped. A fetch accepted in that same cycle still reads at the old `pc`.
- R8: At most one external read is outstanding. While `ext_req` is high, `req_ready` is low and `ext_addr` does not change.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and `req_ready` is low.
- R10: Two fetches in a row, an opcode and then its immediate, return the words at `pc` and `pc`+1, in that order, and advance `pc` by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_fetch | input | 1 | 1: fetch at PC and advance it; 0: data read at `req_addr` |
| req_addr | input | 16 | Word address for data reads |
| rsp_valid | output | 1 | Fetched word valid |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_data | output | 16 | Fetched word |
| pc_load | input | 1 | Load the PC (branch or call) |
| pc_load_val | input | 16 | New PC value |
| pc | output | 16 | Current program counter |
| iram_we | input | 1 | Instruction RAM write strobe |
| iram_waddr | input | 10 | Instruction RAM write address |
| iram_wdata | input | 16 | Instruction RAM write data |
| ext_req | output | 1 | External read request, held until acknowledged |
| ext_addr | output | 17 | External byte address |
| ext_ack | input | 1 | External read done, one-cycle pulse |
| ext_data | input | 16 | External read data, valid with `ext_ack` |

## Verification
The assertions assume that `ext_ack` is pulsed only while `ext_req` is high, and they check this. They also assume that nothing is written to the instruction RAM while reads are running. The bench's external responder answers only after it sees a pending `ext_req`, with a latency that cycles from one to four cycles, and it drops the acknowledge after one cycle. All RAM loading happens before the first request. Requests, PC loads and `rsp_ready` change only just after a rising edge, so a request accepted together with a PC load falls in one well-defined cycle.

// File: rtl/pmf_pkg.sv
`timescale 1ns/1ps
package pmf_pkg;
  // Source of the word currently held on the response stream
  typedef enum logic {
    SRC_IRAM = 1'b0,
    SRC_EXT  = 1'b1
  } rsp_src_e;
endpackage

// File: rtl/pmf_pc_reg.sv
`timescale 1ns/1ps
module pmf_pc_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  // A load wins over the increment; the increment wraps at the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (load) pc_q <= load_val;
    else if (step) pc_q <= pc_q + ONE;
  end
endmodule

// File: rtl/pmf_iram.sv
`timescale 1ns/1ps
module pmf_iram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read: the output changes only on a read, so it holds between reads
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pmf_ext_port.sv
`timescale 1ns/1ps
module pmf_ext_port #(
  parameter int DW   = 16,
  parameter int WA_W = 16,
  localparam int BA_W = WA_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WA_W-1:0] word_addr,
  output logic            ext_req,
  output logic [BA_W-1:0] ext_addr,
  input  logic            ext_ack,
  input  logic [DW-1:0]   ext_data,
  output logic            done,
  output logic [DW-1:0]   data_q
);
  // The handshake completes in the cycle where the request meets the acknowledge
  assign done = ext_req && ext_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_req  <= 1'b0;
      ext_addr <= '0;
    end else if (done) begin
      ext_req  <= 1'b0;
    end else if (start && !ext_req) begin
      ext_req  <= 1'b1;
      ext_addr <= {word_addr, 1'b0};   // byte address = 2 * word address
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= ext_data;
  end
endmodule

// File: rtl/pmf_fetch_unit.sv
`timescale 1ns/1ps
module pmf_fetch_unit #(
  parameter int PC_W       = 16,
  parameter int DW         = 16,
  parameter int IRAM_DEPTH = 1024,
  localparam int IAW       = $clog2(IRAM_DEPTH),
  localparam int BA_W      = PC_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_fetch,
  input  logic [PC_W-1:0] req_addr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  input  logic            pc_load,
  input  logic [PC_W-1:0] pc_load_val,
  output logic [PC_W-1:0] pc,
  input  logic            iram_we,
  input  logic [IAW-1:0]  iram_waddr,
  input  logic [DW-1:0]   iram_wdata,
  output logic            ext_req,
  output logic [BA_W-1:0] ext_addr,
  input  logic            ext_ack,
  input  logic [DW-1:0]   ext_data
);
  import pmf_pkg::*;

  localparam logic [PC_W-1:0] BOUNDARY = PC_W'(IRAM_DEPTH);

  logic [PC_W-1:0] sel_addr;
  logic            accept;
  logic            to_ext;
  logic            ext_done;
  logic [DW-1:0]   ext_word;
  logic [DW-1:0]   iram_word;
  rsp_src_e        src_q;

  // Steering: one address, one unsigned compare
  assign sel_addr  = req_fetch ? pc : req_addr;
  assign to_ext    = sel_addr >= BOUNDARY;
  assign req_ready = !ext_req && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  pmf_pc_reg #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept && req_fetch),
    .load     (pc_load),
    .load_val (pc_load_val),
    .pc_q     (pc)
  );

  pmf_iram #(.DW(DW), .DEPTH(IRAM_DEPTH)) u_iram (
    .clk   (clk),
    .we    (iram_we),
    .waddr (iram_waddr),
    .wdata (iram_wdata),
    .re    (accept && !to_ext),
    .raddr (sel_addr[IAW-1:0]),
    .rdata (iram_word)
  );

  pmf_ext_port #(.DW(DW), .WA_W(PC_W)) u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && to_ext),
    .word_addr (sel_addr),
    .ext_req   (ext_req),
    .ext_addr  (ext_addr),
    .ext_ack   (ext_ack),
    .ext_data  (ext_data),
    .done      (ext_done),
    .data_q    (ext_word)
  );

  // Output stream: a word is held until the consumer takes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_IRAM;
    end else if (accept && !to_ext) begin
      rsp_valid <= 1'b1;
      src_q     <= SRC_IRAM;
    end else if (ext_done) begin
      rsp_valid <= 1'b1;
      src_q     <= SRC_EXT;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_data = (src_q == SRC_EXT) ? ext_word : iram_word;
endmodule

// File: rtl/pmf_fetch_checker.sv
`timescale 1ns/1ps
module pmf_fetch_checker #(
  parameter int PC_W = 16,
  parameter int DW   = 16,
  localparam int BA_W = PC_W + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_fetch,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_data,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_load_val,
  input logic [PC_W-1:0] pc,
  input logic            ext_req,
  input logic [BA_W-1:0] ext_addr,
  input logic            ext_ack
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  // R3: an external request always carries an even byte address in the upper region
  a_r3_ext_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_addr[0] == 1'b0 && ext_addr[BA_W-1:1] >= PC_W'(1024)));

  // R4: input assumption, acknowledge only while a request is pending
  a_r4_ack_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> ext_req);

  // R4: a completed handshake yields a response and clears the request
  a_r4_ack_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && ext_ack) |=> (rsp_valid && !ext_req));

  // R5: a fetch without a load advances the PC by one
  a_r5_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fetch && !pc_load) |=> (pc == $past(pc) + ONE));

  // R6: a data read without a load leaves the PC alone
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_fetch && !pc_load) |=> $stable(pc));

  // R7: a load sets the PC in the next cycle
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> (pc == $past(pc_load_val)));

  // R8: a single outstanding external read with a stable address
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> !req_ready);
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

  // R9: a response that is not taken is held
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind pmf_fetch_unit pmf_fetch_checker #(.PC_W(PC_W), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_fetch   (req_fetch),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .pc_load     (pc_load),
  .pc_load_val (pc_load_val),
  .pc          (pc),
  .ext_req     (ext_req),
  .ext_addr    (ext_addr),
  .ext_ack     (ext_ack)
);

// File: tb/pmf_fetch_unit_test.sv
`timescale 1ns/1ps
module pmf_fetch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic        pc_load = 1'b0;
  logic [15:0] pc_load_val = '0;
  logic        iram_we = 1'b0;
  logic [9:0]  iram_waddr = '0;
  logic [15:0] iram_wdata = '0;
  logic        ext_ack = 1'b0;
  logic [15:0] ext_data = '0;
  logic        req_ready, rsp_valid, ext_req;
  logic [15:0] rsp_data, pc;
  logic [16:0] ext_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] mpc = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pmf_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fetch(req_fetch), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .pc_load(pc_load),
    .pc_load_val(pc_load_val), .pc(pc), .iram_we(iram_we),
    .iram_waddr(iram_waddr), .iram_wdata(iram_wdata), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_data(ext_data)
  );

  function automatic logic [15:0] iram_word(int i);
    return 16'(i * 947 + 123);
  endfunction

  function automatic logic [15:0] ext_word(logic [15:0] wa);
    return wa ^ 16'hC35A;
  endfunction

  function automatic logic [15:0] exp_word(logic [15:0] a);
    return (a < 16'd1024) ? iram_word(int'(a)) : ext_word(a);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: pushes the expected word, then holds the request until accepted
  task automatic send(bit fetch, logic [15:0] addr, string tag);
    logic [15:0] a;
    a = fetch ? mpc : addr;
    if (fetch) mpc = mpc + 16'd1;
    req_valid = 1'b1; req_fetch = fetch; req_addr = addr;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(exp_word(a));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic load_pc(logic [15:0] v);
    pc_load = 1'b1; pc_load_val = v; mpc = v;
    @(posedge clk); #1;
    pc_load = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60; i++) begin
      if (exp_q.size() == 0 && !ext_req && !rsp_valid) break;
      @(posedge clk); #1;
    end
  endtask

  // Monitor: compares every word the consumer takes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected response", 32'(rsp_data), 32'hFFFF_FFFF);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, 32'(rsp_data), 32'(e));
        end
      end
    end
  end

  // External responder with a latency that cycles from 1 to 4
  initial begin
    int lat;
    lat = 1;
    forever begin
      @(negedge clk);
      if (rst_n && ext_req) begin
        check(ext_addr[0] == 1'b0 && ext_addr[16:1] >= 16'd1024,
              "R3 ext byte address", 32'(ext_addr), 32'(ext_addr) & ~32'h1);
        check(!req_ready, "R8 busy blocks requests", 32'(req_ready), 32'h0);
        repeat (lat) @(negedge clk);
        ext_data = ext_word(ext_addr[16:1]);
        ext_ack  = 1'b1;
        @(negedge clk);
        ext_ack  = 1'b0;
        lat = lat % 4 + 1;
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(pc == 16'd0, "R1 pc", 32'(pc), 32'h0);
    check(!rsp_valid && !ext_req, "R1 idle outputs", {30'd0, rsp_valid, ext_req}, 32'h0);
    check(req_ready, "R1 ready", 32'(req_ready), 32'h1);
    @(posedge clk); #1;

    // Fill the instruction RAM through the load port (R2)
    for (int i = 0; i < 1024; i++) begin
      iram_we = 1'b1; iram_waddr = 10'(i); iram_wdata = iram_word(i);
      @(posedge clk); #1;
    end
    iram_we = 1'b0;

    // R10 / R5: opcode + immediate pairs back to back
    send(1'b1, 16'h0, "R10 opcode word");
    send(1'b1, 16'h0, "R10 immediate word");
    send(1'b1, 16'h0, "R5 fetch 2");
    send(1'b1, 16'h0, "R5 fetch 3");
    drain();
    check(pc == 16'd4, "R10 pc advance", 32'(pc), 32'd4);

    // R6: data reads leave the PC alone
    send(1'b0, 16'd17, "R6 data read 17");
    send(1'b0, 16'd1023, "R2 last internal word");
    send(1'b0, 16'd5, "R6 data read 5");
    drain();
    check(pc == 16'd4, "R6 pc unchanged", 32'(pc), 32'd4);

    // R2: one-cycle internal latency
    send(1'b0, 16'd200, "R2 latency word");
    check(rsp_valid, "R2 valid one cycle after accept", 32'(rsp_valid), 32'h1);
    drain();

    // R3 / R4: external reads at the boundary and above
    send(1'b0, 16'd1024, "R3 boundary word");
    send(1'b0, 16'h8001, "R4 ext word 8001");
    send(1'b0, 16'hFFFF, "R4 ext word FFFF");
    drain();
    check(pc == 16'd4, "R6 pc after ext reads", 32'(pc), 32'd4);

    // R7: load, then fetch across the boundary
    load_pc(16'h03FE);
    send(1'b1, 16'h0, "R7 fetch 3FE");
    send(1'b1, 16'h0, "R7 fetch 3FF");
    send(1'b1, 16'h0, "R3 fetch 400 external");
    drain();
    check(pc == 16'h0401, "R7 pc after loaded fetches", 32'(pc), 32'h401);

    // R5: wrap at 0xFFFF
    load_pc(16'hFFFF);
    send(1'b1, 16'h0, "R5 fetch FFFF");
    send(1'b1, 16'h0, "R5 fetch after wrap");
    drain();
    check(pc == 16'h0001, "R5 pc wrap", 32'(pc), 32'h1);

    // R7: load in the same cycle as a fetch; the fetch uses the old pc
    pc_load = 1'b1; pc_load_val = 16'h0100;
    send(1'b1, 16'h0, "R7 fetch with load");
    pc_load = 1'b0;
    mpc = 16'h0100;
    drain();
    check(pc == 16'h0100, "R7 load beats increment", 32'(pc), 32'h100);

    // R9: back-pressure
    rsp_ready = 1'b0;
    send(1'b0, 16'd33, "R9 held word");
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check(rsp_valid, "R9 valid held", 32'(rsp_valid), 32'h1);
    check(rsp_data == iram_word(33), "R9 data held", 32'(rsp_data), 32'(iram_word(33)));
    check(!req_ready, "R9 ready low while held", 32'(req_ready), 32'h0);
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    drain();
    check(exp_q.size() == 0, "R9 all responses taken", 32'(exp_q.size()), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule